// File: doc/BRIEF.md
# Synchronous burst port controller

This block is the device side of a parallel 16-bit memory port that runs on a clock supplied by the host. When the host pulls chip select low with a read or write strobe, the block samples the request on a rising edge. It counts a programmable first-word latency, then moves one data word per clock, or one word per two clocks when the hold setting is on. Read words are fetched from a word source and driven onto the data bus. Write words are taken from the bus and handed to a word sink. The burst runs for as long as chip select stays low and ends on the first edge that finds it high.

A small register space sits beside the data space: a control register, an abort register for write bursts, and a general scratch register. While bursting is enabled, only the control register can be reached, so the host must clear the enable bit before it touches anything else. A device-ID input lets two ports share one bus, with no external decoding: each responds only to addresses whose top bit equals its ID.

The word source uses valid/ready. The port asserts `src_ready` on each edge where it takes a word. If `src_valid` is low at that point, the port keeps its state and raises `wait_o` until the word arrives. The word sink is told of each captured word through `snk_valid`. From the configured wait-start index onward, a low `snk_ready` holds the word on the bus and raises `wait_o`. Before that index, a word is captured whatever `snk_ready` says.

Top module: `syncburst_port`

## Requirements
- R1: After reset the control register reads 0 (bursting off, hold off, latency 0, wait start 0), the scratch register reads 0, and `dq_oe`, `wait_o`, `src_ready` and `snk_valid` are all low.
- R2: Address layout is bit 11 = device select, bit 10 = register space, bits 9:0 = start word address; register index is bits 1:0 (0 control, 1 write abort, 2 scratch). Control bits: 0 enable, 1 hold, 5:2 latency L, 8:6 wait start W. A burst read sampled at edge E0 drives its first word for the host to latch at edge E0+2+L; `dq_oe` stays low before the edge E0+1+L.
- R3: With hold 0, word i of a read burst comes from word address (start+i) mod 1024, and each word changes on every edge.
- R4: With hold 1, each read word stays on the bus across two rising edges before the next word appears.
- R5: A burst needs no edge after its last word (or after the first edge of the last word with hold 1). An edge that samples `cs_n` high ends any access, and `dq_oe` is low after that edge.
- R6: While enable is 1, writes to any register except control are dropped and reads of them return 0. The control register can still be read and written, and clearing enable restores access.
- R7: In a write burst, a write cycle to register index 1 drops the current word and returns the port to idle. No later word is captured until a new burst starts.
- R8: In a write burst, word i is captured on its edge (`snk_valid` high, `snk_data` = bus). For i < W, `wait_o` stays low and the word is captured even with `snk_ready` low. For i >= W, a low `snk_ready` raises `wait_o` and the word is held.
- R9: An access whose device-select bit differs from `dev_id` has no effect: no register write, `dq_oe` stays low, and no burst starts.
- R10: With enable 0, data-space accesses are ignored: `dq_oe`, `src_ready` and `snk_valid` stay low.
- R11: If `src_valid` is low when the port takes a read word, `wait_o` is high, the bus holds its previous state, and the word is taken on the first edge with `src_valid` high.
- R12: A register read drives the selected register on `dq_o` after the edge that samples it, and a register write takes effect on the edge that samples it. The control register reads back bits 8:0 as written, with bits 15:9 as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host-supplied port clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_id | input | 1 | Identity of this device on a shared bus |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 12 | Device select, register-space flag and word address |
| dq_i | input | 16 | Write data from the host |
| dq_o | output | 16 | Read data to the host |
| dq_oe | output | 1 | Drive enable for the data bus |
| wait_o | output | 1 | Wait indication to the host |
| src_addr | output | 10 | Word address of the next read word |
| src_data | input | 16 | Word from the source |
| src_valid | input | 1 | Source word is present |
| src_ready | output | 1 | Port takes the source word on this edge |
| snk_data | output | 16 | Captured write word |
| snk_valid | output | 1 | A write word is captured on this edge |
| snk_ready | input | 1 | Sink can accept a word |

## Verification
The bench builds the block with its default parameters: 16-bit data, a 12-bit address and therefore a 10-bit word address. With these values a burst that starts near the top of the word space shows the address wrapping to zero. The 4-bit latency field lets a nested sweep cover all sixteen latencies with both hold settings, and the 3-bit wait-start field allows a wait gated at the last saturating index.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

  localparam int unsigned LAT_W  = 4;
  localparam int unsigned WST_W  = 3;
  localparam int unsigned RIDX_W = 2;

  localparam logic [RIDX_W-1:0] RIDX_CTRL = 2'd0;
  localparam logic [RIDX_W-1:0] RIDX_EXIT = 2'd1;
  localparam logic [RIDX_W-1:0] RIDX_SCR  = 2'd2;

  // control word, enable in the least significant bit
  typedef struct packed {
    logic [WST_W-1:0] wst;
    logic [LAT_W-1:0] lat;
    logic             hold;
    logic             en;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  typedef enum logic [2:0] {
    S_IDLE,
    S_LAT,
    S_RDAT,
    S_WDAT,
    S_RREG
  } seq_st_t;

endpackage

// File: rtl/sbp_decode.sv
module sbp_decode
  import sbp_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              dev_id,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_cyc,
  output logic              wr_cyc,
  output logic              reg_sp,
  output logic [RIDX_W-1:0] reg_idx,
  output logic [ADDR_W-3:0] word_addr
);
  localparam int unsigned WA_W = ADDR_W - 2;

  logic sel;
  logic act;

  // the top address bit picks one of two devices on a shared bus
  assign sel       = (addr[ADDR_W-1] == dev_id);
  assign act       = !cs_n && sel;
  assign rd_cyc    = act && !oe_n && we_n;
  assign wr_cyc    = act && !we_n;
  assign reg_sp    = addr[ADDR_W-2];
  assign reg_idx   = addr[RIDX_W-1:0];
  assign word_addr = addr[WA_W-1:0];

endmodule

// File: rtl/sbp_regs.sv
module sbp_regs
  import sbp_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [RIDX_W-1:0] idx,
  input  logic [DATA_W-1:0] wdata,
  output ctrl_t             ctrl_o,
  output logic [DATA_W-1:0] rdata
);
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] scr_q;
  logic              fenced;

  assign fenced = ctrl_q.en;
  assign ctrl_o = ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      scr_q  <= '0;
    end else if (wr_en) begin
      if (idx == RIDX_CTRL) begin
        ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
      end else if (idx == RIDX_SCR && !fenced) begin
        scr_q <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (idx == RIDX_CTRL) begin
      rdata = DATA_W'(ctrl_q);
    end else if (idx == RIDX_SCR && !fenced) begin
      rdata = scr_q;
    end
  end

  // R6
  fence_scr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx != RIDX_CTRL && ctrl_q.en) |=> $stable(scr_q));

  // R6
  fence_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.en && idx == RIDX_SCR) |-> (rdata == '0));

endmodule

// File: rtl/sbp_seq.sv
module sbp_seq
  import sbp_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned WA_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_cyc,
  input  logic              wr_cyc,
  input  logic              reg_sp,
  input  logic [RIDX_W-1:0] reg_idx,
  input  logic [WA_W-1:0]   word_addr,
  input  ctrl_t             ctrl_i,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic [DATA_W-1:0] dq_i,
  input  logic [DATA_W-1:0] src_data,
  input  logic              src_valid,
  input  logic              snk_ready,
  output logic              reg_wr_en,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  output logic              wait_o,
  output logic [WA_W-1:0]   src_addr,
  output logic              src_ready,
  output logic [DATA_W-1:0] snk_data,
  output logic              snk_valid
);
  seq_st_t           st;
  logic [LAT_W-1:0]  cnt;
  logic              is_wr;
  logic              phase;
  logic [WST_W-1:0]  widx;
  logic [WA_W-1:0]   waddr;
  logic [DATA_W-1:0] dq_q;
  logic              oe_q;

  logic start_rd, start_wr, start_rr;
  logic exit_hit, hold_edge, rd_load, rd_stall;
  logic w_gate, w_slot;

  assign reg_wr_en = (st == S_IDLE) && wr_cyc && reg_sp;
  assign start_rd  = (st == S_IDLE) && rd_cyc && !reg_sp && ctrl_i.en;
  assign start_wr  = (st == S_IDLE) && wr_cyc && !reg_sp && ctrl_i.en;
  assign start_rr  = (st == S_IDLE) && rd_cyc && reg_sp;
  assign exit_hit  = (st == S_WDAT) && wr_cyc && reg_sp && (reg_idx == RIDX_EXIT);

  // first edge of a held word keeps it on the bus
  assign hold_edge = ctrl_i.hold && !phase;
  assign rd_load   = !cs_n && (((st == S_LAT) && (cnt == '0) && !is_wr) ||
                               ((st == S_RDAT) && !hold_edge));
  assign rd_stall  = rd_load && !src_valid;

  // waits are only allowed from the configured word index onward
  assign w_gate    = (widx >= ctrl_i.wst);
  assign w_slot    = !cs_n && (st == S_WDAT) && !phase && !exit_hit;

  assign src_ready = rd_load;
  assign src_addr  = waddr;
  assign snk_data  = dq_i;
  assign snk_valid = w_slot && !(w_gate && !snk_ready);
  assign wait_o    = rd_stall || (w_slot && w_gate && !snk_ready);
  assign dq_o      = dq_q;
  assign dq_oe     = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      is_wr <= 1'b0;
      phase <= 1'b0;
      widx  <= '0;
      waddr <= '0;
      dq_q  <= '0;
      oe_q  <= 1'b0;
    end else if (st != S_IDLE && cs_n) begin
      st    <= S_IDLE;
      oe_q  <= 1'b0;
      phase <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (start_rd || start_wr) begin
            st    <= S_LAT;
            cnt   <= ctrl_i.lat;
            is_wr <= start_wr;
            waddr <= word_addr;
            widx  <= '0;
            phase <= 1'b0;
          end else if (start_rr) begin
            st   <= S_RREG;
            dq_q <= reg_rdata;
            oe_q <= 1'b1;
          end
        end
        S_LAT: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (is_wr) begin
            st    <= S_WDAT;
            phase <= 1'b0;
          end else if (src_valid) begin
            st    <= S_RDAT;
            dq_q  <= src_data;
            oe_q  <= 1'b1;
            waddr <= waddr + 1'b1;
            phase <= 1'b0;
          end
        end
        S_RDAT: begin
          if (hold_edge) begin
            phase <= 1'b1;
          end else if (src_valid) begin
            dq_q  <= src_data;
            waddr <= waddr + 1'b1;
            phase <= 1'b0;
          end
        end
        S_WDAT: begin
          if (exit_hit) begin
            st    <= S_IDLE;
            phase <= 1'b0;
          end else if (phase) begin
            phase <= 1'b0;
          end else if (snk_valid) begin
            if (widx != '1) widx <= widx + 1'b1;
            waddr <= waddr + 1'b1;
            phase <= ctrl_i.hold;
          end
        end
        S_RREG: begin
          dq_q <= reg_rdata;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R5
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !dq_oe);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !rd_cyc) |=> !dq_oe);

  // R2
  lat_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LAT && cnt != '0 && !cs_n) |=> (st == S_LAT && cnt == $past(cnt) - 1'b1));

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RDAT && !cs_n && ctrl_i.hold && !phase) |=> ($stable(dq_q) && dq_oe));

  // R8
  wait_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WDAT && widx < ctrl_i.wst) |-> !wait_o);

  // R7
  exit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exit_hit |=> (st == S_IDLE && !snk_valid));

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stall && st == S_RDAT) |=> $stable(dq_q));

  // R10
  no_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_i.en |-> (!src_ready && !snk_valid));

endmodule

// File: rtl/syncburst_port.sv
module syncburst_port
  import sbp_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dev_id,
  input  logic                cs_n,
  input  logic                oe_n,
  input  logic                we_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   dq_i,
  output logic [DATA_W-1:0]   dq_o,
  output logic                dq_oe,
  output logic                wait_o,
  output logic [ADDR_W-3:0]   src_addr,
  input  logic [DATA_W-1:0]   src_data,
  input  logic                src_valid,
  output logic                src_ready,
  output logic [DATA_W-1:0]   snk_data,
  output logic                snk_valid,
  input  logic                snk_ready
);
  localparam int unsigned WA_W = ADDR_W - 2;

  logic              rd_cyc, wr_cyc, reg_sp, reg_wr_en;
  logic [RIDX_W-1:0] reg_idx;
  logic [WA_W-1:0]   word_addr;
  logic [DATA_W-1:0] reg_rdata;
  ctrl_t             ctrl;

  sbp_decode #(.ADDR_W(ADDR_W)) u_dec (
    .cs_n      (cs_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .dev_id    (dev_id),
    .addr      (addr),
    .rd_cyc    (rd_cyc),
    .wr_cyc    (wr_cyc),
    .reg_sp    (reg_sp),
    .reg_idx   (reg_idx),
    .word_addr (word_addr)
  );

  sbp_regs #(.DATA_W(DATA_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_wr_en),
    .idx    (reg_idx),
    .wdata  (dq_i),
    .ctrl_o (ctrl),
    .rdata  (reg_rdata)
  );

  sbp_seq #(.DATA_W(DATA_W), .WA_W(WA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .rd_cyc    (rd_cyc),
    .wr_cyc    (wr_cyc),
    .reg_sp    (reg_sp),
    .reg_idx   (reg_idx),
    .word_addr (word_addr),
    .ctrl_i    (ctrl),
    .reg_rdata (reg_rdata),
    .dq_i      (dq_i),
    .src_data  (src_data),
    .src_valid (src_valid),
    .snk_ready (snk_ready),
    .reg_wr_en (reg_wr_en),
    .dq_o      (dq_o),
    .dq_oe     (dq_oe),
    .wait_o    (wait_o),
    .src_addr  (src_addr),
    .src_ready (src_ready),
    .snk_data  (snk_data),
    .snk_valid (snk_valid)
  );

endmodule

// File: tb/syncburst_port_tb_top.sv
module syncburst_port_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dev_id = 1'b0;
  logic        cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [11:0] addr = '0;
  logic [15:0] dq_i = '0;
  logic [15:0] dq_o;
  logic        dq_oe, wait_o;
  logic [9:0]  src_addr;
  logic [15:0] src_data;
  logic        src_valid = 1'b1;
  logic        src_ready;
  logic [15:0] snk_data;
  logic        snk_valid;
  logic        snk_ready = 1'b1;

  int checks = 0;
  int errors = 0;
  logic dsel = 1'b0;
  int sink_n = 0;
  logic [15:0] sink_mem [0:15];

  always #(CLK_P/2) clk = ~clk;

  assign src_data = {6'h2A, src_addr};

  syncburst_port dut_i (
    .clk(clk), .rst_n(rst_n), .dev_id(dev_id), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe), .wait_o(wait_o),
    .src_addr(src_addr), .src_data(src_data), .src_valid(src_valid), .src_ready(src_ready),
    .snk_data(snk_data), .snk_valid(snk_valid), .snk_ready(snk_ready)
  );

  always @(posedge clk) begin
    if (snk_valid) begin
      if (sink_n < 16) sink_mem[sink_n] = snk_data;
      sink_n = sink_n + 1;
    end
  end

  typedef struct packed {
    logic [3:0] lat;
    logic       hold;
    logic [3:0] n;
    logic [9:0] start;
  } rvec_t;

  localparam rvec_t RVEC [8] = '{
    '{4'd0,  1'b0, 4'd4, 10'h000},
    '{4'd1,  1'b0, 4'd5, 10'h010},
    '{4'd3,  1'b1, 4'd3, 10'h123},
    '{4'd0,  1'b1, 4'd4, 10'h3FE},
    '{4'd15, 1'b0, 4'd2, 10'h200},
    '{4'd15, 1'b1, 4'd3, 10'h0FF},
    '{4'd7,  1'b0, 4'd6, 10'h3FD},
    '{4'd2,  1'b1, 4'd1, 10'h055}
  };

  function automatic logic [15:0] rexp(input logic [9:0] a);
    return {6'h2A, a};
  endfunction

  function automatic logic [15:0] wword(input int i);
    return 16'h7100 + 16'(i * 3);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic reg_wr(input logic [1:0] idx, input logic [15:0] v);
    @(negedge clk);
    cs_n = 0; we_n = 0; oe_n = 1; addr = {dsel, 1'b1, 8'd0, idx}; dq_i = v;
    @(posedge clk);
    @(negedge clk);
    cs_n = 1; we_n = 1;
  endtask

  task automatic reg_rd(input logic [1:0] idx, output logic [15:0] v, output logic oe);
    @(negedge clk);
    cs_n = 0; oe_n = 0; we_n = 1; addr = {dsel, 1'b1, 8'd0, idx};
    @(posedge clk);
    @(negedge clk);
    v = dq_o; oe = dq_oe;
    cs_n = 1; oe_n = 1;
  endtask

  task automatic set_ctrl(input logic [2:0] wst, input logic [3:0] lat, input logic hold, input logic en);
    reg_wr(2'd0, {7'd0, wst, lat, hold, en});
  endtask

  task automatic burst_rd(input logic [3:0] lat, input logic hold, input int n, input logic [9:0] start);
    set_ctrl(3'd0, lat, hold, 1'b1);
    @(negedge clk);
    cs_n = 0; oe_n = 0; we_n = 1; addr = {dsel, 1'b0, start};
    @(posedge clk);
    repeat (int'(lat)) @(posedge clk);
    @(negedge clk);
    chk("R2 no early word", {31'd0, dq_oe}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      chk("R2 word valid", {31'd0, dq_oe}, 32'd1);
      chk("R3 word data", {16'd0, dq_o}, {16'd0, rexp(start + 10'(i))});
      if (hold && i < n - 1) begin
        @(posedge clk);
        @(negedge clk);
        chk("R4 held word", {16'd0, dq_o}, {16'd0, rexp(start + 10'(i))});
      end
      if (i < n - 1) begin
        @(posedge clk);
        @(negedge clk);
      end
    end
    cs_n = 1; oe_n = 1;
    @(posedge clk);
    @(negedge clk);
    chk("R5 bus released", {31'd0, dq_oe}, 32'd0);
  endtask

  task automatic burst_wr(input logic [3:0] lat, input logic hold, input logic [2:0] wst,
                          input int n, input logic [7:0] stall);
    set_ctrl(wst, lat, hold, 1'b1);
    sink_n = 0;
    @(negedge clk);
    cs_n = 0; we_n = 0; oe_n = 1; addr = {dsel, 1'b0, 10'h040}; dq_i = 16'h0;
    @(posedge clk);
    repeat (int'(lat) + 1) @(posedge clk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dq_i = wword(i);
      snk_ready = !stall[i];
      #1;
      chk("R8 wait by index", {31'd0, wait_o}, {31'd0, stall[i] && (i >= int'(wst))});
      if (stall[i] && i >= int'(wst)) begin
        @(posedge clk);
        @(negedge clk);
        snk_ready = 1;
        #1;
        chk("R8 wait cleared", {31'd0, wait_o}, 32'd0);
      end
      @(posedge clk);
      snk_ready = 1;
      if (hold && i < n - 1) begin
        @(negedge clk);
        @(posedge clk);
      end
    end
    @(negedge clk);
    cs_n = 1; we_n = 1;
    @(posedge clk);
    chk("R8 word count", sink_n, n);
    for (int i = 0; i < n; i++) chk("R8 word data", {16'd0, sink_mem[i]}, {16'd0, wword(i)});
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic        oe;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk("R1 dq_oe", {31'd0, dq_oe}, 32'd0);
    chk("R1 wait", {31'd0, wait_o}, 32'd0);
    chk("R1 src_ready", {31'd0, src_ready}, 32'd0);
    chk("R1 snk_valid", {31'd0, snk_valid}, 32'd0);
    reg_rd(2'd0, v, oe);
    chk("R1 ctrl", {16'd0, v}, 32'd0);
    reg_rd(2'd2, v, oe);
    chk("R1 scratch", {16'd0, v}, 32'd0);

    // R12 register access and control layout
    reg_wr(2'd0, 16'hFFAA);
    reg_rd(2'd0, v, oe);
    chk("R12 ctrl readback", {16'd0, v}, 32'h01AA);
    chk("R12 read drive", {31'd0, oe}, 32'd1);
    reg_wr(2'd2, 16'hBEEF);
    reg_rd(2'd2, v, oe);
    chk("R12 scratch readback", {16'd0, v}, 32'hBEEF);
    reg_wr(2'd0, 16'h0000);

    // R10 data access with bursting off
    @(negedge clk);
    cs_n = 0; oe_n = 0; we_n = 1; addr = {dsel, 1'b0, 10'h001};
    for (int k = 0; k < 6; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R10 no read drive", {30'd0, dq_oe, src_ready}, 32'd0);
    end
    oe_n = 1; we_n = 0; #1;
    chk("R10 no write capture", {31'd0, snk_valid}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    cs_n = 1; we_n = 1;

    // R2 R3 R4 R5 table walk
    for (int t = 0; t < 8; t++) burst_rd(RVEC[t].lat, RVEC[t].hold, int'(RVEC[t].n), RVEC[t].start);

    // R2 every latency with both hold settings
    for (int l = 0; l < 16; l++)
      for (int h = 0; h < 2; h++) burst_rd(4'(l), 1'(h), 2, 10'(l * 7 + h));

    // R6 fence
    set_ctrl(3'd0, 4'd0, 1'b0, 1'b1);
    reg_wr(2'd2, 16'h1234);
    reg_rd(2'd2, v, oe);
    chk("R6 fenced read", {16'd0, v}, 32'd0);
    reg_rd(2'd0, v, oe);
    chk("R6 ctrl reachable", {16'd0, v}, 32'h0001);
    reg_wr(2'd0, 16'h0000);
    reg_rd(2'd2, v, oe);
    chk("R6 write dropped", {16'd0, v}, 32'hBEEF);

    // R8 wait gating
    burst_wr(4'd0, 1'b0, 3'd2, 5, 8'b0000_0101);
    burst_wr(4'd2, 1'b1, 3'd1, 4, 8'b0000_1010);
    burst_wr(4'd1, 1'b0, 3'd7, 8, 8'b1000_0001);

    // R7 write abort
    set_ctrl(3'd0, 4'd1, 1'b0, 1'b1);
    sink_n = 0;
    @(negedge clk);
    cs_n = 0; we_n = 0; oe_n = 1; addr = {dsel, 1'b0, 10'h000};
    @(posedge clk);
    repeat (2) @(posedge clk);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); dq_i = wword(i);
      @(posedge clk);
    end
    @(negedge clk);
    addr = {dsel, 1'b1, 8'd0, 2'd1}; dq_i = 16'h0001;
    #1;
    chk("R7 abort cycle no capture", {31'd0, snk_valid}, 32'd0);
    @(posedge clk);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); dq_i = wword(5 + k);
      #1;
      chk("R7 idle after abort", {30'd0, snk_valid, wait_o}, 32'd0);
      @(posedge clk);
    end
    chk("R7 captured count", sink_n, 2);
    @(negedge clk);
    cs_n = 1; we_n = 1;

    // R11 source back-pressure
    set_ctrl(3'd0, 4'd0, 1'b0, 1'b1);
    @(negedge clk);
    src_valid = 0;
    cs_n = 0; oe_n = 0; we_n = 1; addr = {dsel, 1'b0, 10'h080};
    @(posedge clk);
    @(negedge clk);
    chk("R11 wait on empty source", {30'd0, wait_o, dq_oe}, 32'd2);
    @(posedge clk);
    @(negedge clk);
    chk("R11 still waiting", {31'd0, dq_oe}, 32'd0);
    src_valid = 1; #1;
    chk("R11 wait drops", {31'd0, wait_o}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R11 first word", {15'd0, dq_oe, dq_o}, {15'd0, 1'b1, rexp(10'h080)});
    src_valid = 0;
    @(posedge clk);
    @(negedge clk);
    chk("R11 held on stall", {16'd0, dq_o}, {16'd0, rexp(10'h080)});
    src_valid = 1;
    @(posedge clk);
    @(negedge clk);
    chk("R11 next word", {16'd0, dq_o}, {16'd0, rexp(10'h081)});
    cs_n = 1; oe_n = 1;
    @(posedge clk);

    // R9 device select
    reg_wr(2'd0, 16'h0000);
    dev_id = 1;
    dsel = 0;
    reg_wr(2'd2, 16'h5555);
    reg_rd(2'd2, v, oe);
    chk("R9 other device read", {31'd0, oe}, 32'd0);
    dsel = 1;
    reg_rd(2'd2, v, oe);
    chk("R9 write ignored", {16'd0, v}, 32'hBEEF);
    set_ctrl(3'd0, 4'd0, 1'b0, 1'b1);
    @(negedge clk);
    cs_n = 0; oe_n = 0; we_n = 1; addr = {1'b0, 1'b0, 10'h010};
    for (int k = 0; k < 4; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R9 no burst for other id", {31'd0, dq_oe}, 32'd0);
    end
    cs_n = 1; oe_n = 1;
    burst_rd(4'd2, 1'b0, 3, 10'h033);
    dsel = 0; dev_id = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule